// File: doc/BRIEF.md
# Subset RISC Instruction Executor

This block executes a small subset of a 32-bit fixed-length load-store instruction set. Instruction words arrive one at a time on a valid/ready handshake. The block decodes each accepted word and reads up to two source registers from a 32-entry, 32-bit register file. For arithmetic and logic operations, it computes the result and writes it back on the clock edge at which the word is accepted. The supported arithmetic forms are add-immediate (signed and unsigned), OR-immediate, load-upper-immediate and register subtract.

Byte and word loads and stores are not performed locally. The block computes the effective address and hands the access to an external memory unit through a registered request port that also uses valid/ready. While a request waits for the memory unit, `instr_ready` is held low, so the instruction stream is back-pressured. The upstream source must keep `instr_word` stable while `instr_valid` is high and `instr_ready` is low. A combinational debug port returns the contents of any register.

Top module: `mini_exec`

## Requirements
- R1: A word is accepted on a rising edge where `instr_valid` and `instr_ready` are both high. `instr_ready` is high exactly when no memory request is pending.
- R2: Opcode 8 (bits 31:26) adds a sign-extended imm[15:0] to register rs[25:21] and writes register rt[20:16]. For example, 0x21840021 writes reg12+33 into reg4.
- R3: Opcode 9 adds a zero-extended immediate to rs and writes rt. Sums wrap modulo 2^32 and raise no trap.
- R4: Opcode 13 writes rt with rs OR the zero-extended immediate.
- R5: Opcode 15 writes rt with the immediate in bits 31:16 and zeros in bits 15:0. A following opcode 13 on the same register completes a full 32-bit constant.
- R6: Opcode 0 with function field bits 5:0 = 34 and shift field bits 10:6 = 0 writes rd[15:11] with rs - rt, wrapping modulo 2^32.
- R7: Register 0 always reads as zero, and writes to it are discarded.
- R8: The write lands on the edge that accepts the word, so an instruction accepted on the next edge reads the new value.
- R9: Any other opcode, or opcode 0 with another function code or a nonzero shift field, drives `illegal` high for exactly the one cycle after acceptance and changes no register.
- R10: Opcodes 32 (byte, sign-extend), 36 (byte, zero-extend), 35 (word load), 40 (byte store) and 43 (word store) raise `mem_req_valid` on the accepting edge. The request carries address rs + sign-extended imm, write data = rt value, register index rt, `mem_req_write` (1 for stores), `mem_req_word` (1 for word size) and `mem_req_signed` (1 only for opcode 32). These opcodes write no register.
- R11: A pending request holds all its fields stable until the edge where `mem_req_ready` is high, and then drops `mem_req_valid`.
- R12: Reset clears every register. `dbg_data` combinationally shows the addressed register, so a write becomes visible only after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Executor can take a word |
| instr_word | input | 32 | Instruction word |
| illegal | output | 1 | One-cycle pulse after an unsupported word is accepted |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory unit takes the request |
| mem_req_write | output | 1 | 1 = store, 0 = load |
| mem_req_word | output | 1 | 1 = word, 0 = byte |
| mem_req_signed | output | 1 | Sign-extend loaded byte |
| mem_req_reg | output | 5 | Load destination or store source register |
| mem_req_addr | output | 32 | Effective byte address |
| mem_req_wdata | output | 32 | Store data |
| dbg_addr | input | 5 | Debug register index |
| dbg_data | output | 32 | Debug register contents |

## Verification
The bench provokes two kinds of same-cycle overlap. In the first, a register write and a read of the same register fall in one cycle. Dependent instructions are driven on consecutive edges, and the debug port is pointed at the destination during the accepting cycle: it must show the old value before the edge and the new value after it. In the second, a pending memory request and a newly offered instruction overlap. An arithmetic word is held valid while `mem_req_ready` is low. That word must not be taken until the cycle after the request retires, and the request fields must stay frozen meanwhile.

// File: rtl/mx_pkg.sv
package mx_pkg;
  localparam int XLEN = 32;
  localparam int REG_AW = 5;
  localparam int IMM_W = 16;

  localparam logic [5:0] OPC_SPECIAL = 6'd0;
  localparam logic [5:0] OPC_ADDI    = 6'd8;
  localparam logic [5:0] OPC_ADDIU   = 6'd9;
  localparam logic [5:0] OPC_ORI     = 6'd13;
  localparam logic [5:0] OPC_LUI     = 6'd15;
  localparam logic [5:0] OPC_LB      = 6'd32;
  localparam logic [5:0] OPC_LW      = 6'd35;
  localparam logic [5:0] OPC_LBU     = 6'd36;
  localparam logic [5:0] OPC_SB      = 6'd40;
  localparam logic [5:0] OPC_SW      = 6'd43;
  localparam logic [5:0] FN_SUB      = 6'd34;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR, ALU_PASSB} alu_op_e;

  typedef struct packed {
    alu_op_e             alu;
    logic                use_imm;
    logic                wr_en;
    logic [REG_AW-1:0]   wr_idx;
    logic                is_mem;
    logic                mem_wr;
    logic                mem_word;
    logic                mem_signed;
    logic                bad;
    logic [XLEN-1:0]     imm;
  } dec_t;
endpackage

// File: rtl/mx_decode.sv
module mx_decode
  import mx_pkg::*;
(
  input  logic [XLEN-1:0]   word,
  output logic [REG_AW-1:0] rs_idx,
  output logic [REG_AW-1:0] rt_idx,
  output dec_t              dec
);
  localparam int EXT_W = XLEN - IMM_W;

  logic [5:0]        opc;
  logic [5:0]        fn;
  logic [4:0]        shamt;
  logic [REG_AW-1:0] rd_idx;
  logic [IMM_W-1:0]  imm16;
  logic [XLEN-1:0]   imm_sx;
  logic [XLEN-1:0]   imm_zx;

  assign opc    = word[31:26];
  assign rs_idx = word[25:21];
  assign rt_idx = word[20:16];
  assign rd_idx = word[15:11];
  assign shamt  = word[10:6];
  assign fn     = word[5:0];
  assign imm16  = word[IMM_W-1:0];
  assign imm_sx = {{EXT_W{imm16[IMM_W-1]}}, imm16};
  assign imm_zx = {{EXT_W{1'b0}}, imm16};

  always_comb begin
    dec         = '0;
    dec.alu     = ALU_ADD;
    dec.wr_idx  = rt_idx;
    dec.imm     = imm_sx;
    case (opc)
      OPC_ADDI: begin
        dec.use_imm = 1'b1;
        dec.wr_en   = 1'b1;
      end
      OPC_ADDIU: begin
        dec.use_imm = 1'b1;
        dec.wr_en   = 1'b1;
        dec.imm     = imm_zx;
      end
      OPC_ORI: begin
        dec.alu     = ALU_OR;
        dec.use_imm = 1'b1;
        dec.wr_en   = 1'b1;
        dec.imm     = imm_zx;
      end
      OPC_LUI: begin
        dec.alu     = ALU_PASSB;
        dec.use_imm = 1'b1;
        dec.wr_en   = 1'b1;
        dec.imm     = {imm16, {EXT_W{1'b0}}};
      end
      OPC_SPECIAL: begin
        if (fn == FN_SUB && shamt == 5'd0) begin
          dec.alu    = ALU_SUB;
          dec.wr_en  = 1'b1;
          dec.wr_idx = rd_idx;
        end else begin
          dec.bad = 1'b1;
        end
      end
      OPC_LB, OPC_LBU, OPC_LW, OPC_SB, OPC_SW: begin
        dec.is_mem     = 1'b1;
        dec.use_imm    = 1'b1;
        dec.mem_wr     = (opc == OPC_SB) || (opc == OPC_SW);
        dec.mem_word   = (opc == OPC_LW) || (opc == OPC_SW);
        dec.mem_signed = (opc == OPC_LB);
      end
      default: dec.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/mx_regfile.sv
module mx_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  input  logic [AW-1:0] ra_dbg,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  output logic [W-1:0]  rd_dbg,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a   = (ra_a   == '0) ? '0 : regs[ra_a];
  assign rd_b   = (ra_b   == '0) ? '0 : regs[ra_b];
  assign rd_dbg = (ra_dbg == '0) ? '0 : regs[ra_dbg];
endmodule

// File: rtl/mx_alu.sv
module mx_alu
  import mx_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = b;
    endcase
  end
endmodule

// File: rtl/mini_exec.sv
module mini_exec
  import mx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [XLEN-1:0]   instr_word,
  output logic              illegal,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic              mem_req_word,
  output logic              mem_req_signed,
  output logic [REG_AW-1:0] mem_req_reg,
  output logic [XLEN-1:0]   mem_req_addr,
  output logic [XLEN-1:0]   mem_req_wdata,
  input  logic [REG_AW-1:0] dbg_addr,
  output logic [XLEN-1:0]   dbg_data
);
  localparam int NREGS = 1 << REG_AW;

  dec_t              dec;
  logic [REG_AW-1:0] rs_idx;
  logic [REG_AW-1:0] rt_idx;
  logic [XLEN-1:0]   rs_val;
  logic [XLEN-1:0]   rt_val;
  logic [XLEN-1:0]   opnd_b;
  logic [XLEN-1:0]   result;
  logic [XLEN-1:0]   eff_addr;
  logic              accept;
  logic              wr_fire;

  mx_decode u_dec (
    .word   (instr_word),
    .rs_idx (rs_idx),
    .rt_idx (rt_idx),
    .dec    (dec)
  );

  mx_regfile #(.W(XLEN), .N(NREGS)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .ra_a   (rs_idx),
    .ra_b   (rt_idx),
    .ra_dbg (dbg_addr),
    .rd_a   (rs_val),
    .rd_b   (rt_val),
    .rd_dbg (dbg_data),
    .we     (wr_fire),
    .wa     (dec.wr_idx),
    .wd     (result)
  );

  assign opnd_b = dec.use_imm ? dec.imm : rt_val;

  mx_alu #(.W(XLEN)) u_alu (
    .op (dec.alu),
    .a  (rs_val),
    .b  (opnd_b),
    .y  (result)
  );

  assign eff_addr    = rs_val + dec.imm;
  assign instr_ready = !mem_req_valid;
  assign accept      = instr_valid && instr_ready;
  assign wr_fire     = accept && dec.wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      illegal        <= 1'b0;
      mem_req_valid  <= 1'b0;
      mem_req_write  <= 1'b0;
      mem_req_word   <= 1'b0;
      mem_req_signed <= 1'b0;
      mem_req_reg    <= '0;
      mem_req_addr   <= '0;
      mem_req_wdata  <= '0;
    end else begin
      illegal <= accept && dec.bad;
      if (mem_req_valid && mem_req_ready) begin
        mem_req_valid <= 1'b0;
      end else if (accept && dec.is_mem) begin
        mem_req_valid  <= 1'b1;
        mem_req_write  <= dec.mem_wr;
        mem_req_word   <= dec.mem_word;
        mem_req_signed <= dec.mem_signed;
        mem_req_reg    <= rt_idx;
        mem_req_addr   <= eff_addr;
        mem_req_wdata  <= rt_val;
      end
    end
  end
endmodule

// File: rtl/mini_exec_chk.sv
module mini_exec_chk
  import mx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic              instr_ready,
  input logic              illegal,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [XLEN-1:0]   mem_req_addr,
  input logic [XLEN-1:0]   mem_req_wdata,
  input logic [REG_AW-1:0] mem_req_reg,
  input logic [REG_AW-1:0] dbg_addr,
  input logic [XLEN-1:0]   dbg_data
);
  a_r1_stall_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !instr_ready);

  a_r11_request_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata) && $stable(mem_req_reg)));

  a_r11_request_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  a_r9_illegal_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(instr_valid && instr_ready));

  a_r10_request_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> $past(instr_valid && instr_ready));

  a_r7_zero_register: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_addr == '0) |-> (dbg_data == '0));
endmodule

bind mini_exec mini_exec_chk u_chk (.*);

// File: tb/tb_mini_exec.sv
module tb_mini_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [31:0] instr_word = '0;
  logic        illegal;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic        mem_req_write;
  logic        mem_req_word;
  logic        mem_req_signed;
  logic [4:0]  mem_req_reg;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic [4:0]  dbg_addr = '0;
  logic [31:0] dbg_data;

  int n_checks = 0;
  int n_fail = 0;

  mini_exec dut (.*);

  always #10 clk = ~clk;

  function automatic logic [31:0] iw(input int op, input int rs, input int rt, input logic [15:0] imm);
    iw = {op[5:0], rs[4:0], rt[4:0], imm};
  endfunction

  function automatic logic [31:0] rsub(input int rs, input int rt, input int rd);
    rsub = {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, 6'd34};
  endfunction

  // columns: word, debug register, expected value, requirement number
  localparam int NV = 15;
  localparam logic [31:0] VEC [NV][4] = '{
    '{iw(8, 0, 1, 16'd100),    32'd1,  32'd100,      32'd2},  // R2
    '{iw(8, 0, 2, 16'hFFFF),   32'd2,  32'hFFFFFFFF, 32'd2},  // R2 negative
    '{iw(9, 0, 3, 16'hFFFF),   32'd3,  32'h0000FFFF, 32'd3},  // R3
    '{iw(9, 2, 4, 16'd1),      32'd4,  32'd0,        32'd3},  // R3 wrap
    '{iw(15, 0, 5, 16'h1B23),  32'd5,  32'h1B230000, 32'd5},  // R5
    '{iw(13, 5, 5, 16'h4567),  32'd5,  32'h1B234567, 32'd5},  // R5 with R4
    '{iw(13, 0, 6, 16'h8000),  32'd6,  32'h00008000, 32'd4},  // R4
    '{iw(8, 0, 12, 16'd7),     32'd12, 32'd7,        32'd2},
    '{32'h21840021,            32'd4,  32'd40,       32'd2},  // R2 example word
    '{rsub(1, 4, 7),           32'd7,  32'd60,       32'd6},  // R6
    '{rsub(4, 1, 8),           32'd8,  32'hFFFFFFC4, 32'd6},  // R6 wrap
    '{iw(8, 1, 0, 16'd5),      32'd0,  32'd0,        32'd7},  // R7
    '{iw(15, 0, 9, 16'hFFFF),  32'd9,  32'hFFFF0000, 32'd5},
    '{iw(8, 9, 10, 16'hFFFF),  32'd10, 32'hFFFEFFFF, 32'd8},  // R8 back to back
    '{iw(9, 10, 10, 16'd1),    32'd10, 32'hFFFF0000, 32'd8}   // R8 chained
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_reg(input int r, input string req, input logic [31:0] exp);
    dbg_addr = r[4:0];
    #1;
    check(req, dbg_data, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R12 reset state
    check("R12 ready after reset", {31'd0, instr_ready}, 32'd1);
    check("R12 no request after reset", {31'd0, mem_req_valid}, 32'd0);
    check("R9 illegal low after reset", {31'd0, illegal}, 32'd0);
    read_reg(3, "R12 reg cleared", 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // vector table, one instruction per edge
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      instr_valid = 1'b1;
      instr_word  = VEC[i][0];
      @(posedge clk);
      #5;
      read_reg(int'(VEC[i][1]), $sformatf("R%0d vector %0d", VEC[i][3], i), VEC[i][2]);
    end
    @(negedge clk);
    instr_valid = 1'b0;

    // R12/R8: debug read during the write cycle shows old value, then new
    @(negedge clk);
    instr_valid = 1'b1;
    instr_word  = iw(8, 1, 1, 16'd1);
    read_reg(1, "R12 old value before edge", 32'd100);
    @(posedge clk);
    #5;
    read_reg(1, "R8 new value after edge", 32'd101);
    @(negedge clk);
    instr_valid = 1'b0;

    // R9 illegal opcode
    @(negedge clk);
    instr_valid = 1'b1;
    instr_word  = iw(63, 0, 1, 16'd5);
    @(posedge clk);
    #5;
    check("R9 illegal opcode pulse", {31'd0, illegal}, 32'd1);
    read_reg(1, "R9 reg unchanged", 32'd101);
    @(negedge clk);
    instr_valid = 1'b1;
    instr_word  = {6'd0, 5'd1, 5'd1, 5'd1, 5'd0, 6'd32};
    @(posedge clk);
    #5;
    check("R9 illegal function", {31'd0, illegal}, 32'd1);
    read_reg(1, "R9 reg unchanged by function", 32'd101);
    @(negedge clk);
    instr_word  = {6'd0, 5'd1, 5'd4, 5'd1, 5'd3, 6'd34};
    @(posedge clk);
    #5;
    check("R9 shift field nonzero", {31'd0, illegal}, 32'd1);
    read_reg(1, "R9 reg unchanged by shift", 32'd101);
    @(negedge clk);
    instr_valid = 1'b0;
    @(posedge clk);
    #5;
    check("R9 pulse lasts one cycle", {31'd0, illegal}, 32'd0);

    // R10/R11 load with back-pressure from the memory unit
    @(negedge clk);
    mem_req_ready = 1'b0;
    instr_valid = 1'b1;
    instr_word  = iw(35, 1, 11, 16'd8);
    @(posedge clk);
    #5;
    check("R10 load request", {31'd0, mem_req_valid}, 32'd1);
    check("R10 load address", mem_req_addr, 32'd109);
    check("R10 load flags", {29'd0, mem_req_write, mem_req_word, mem_req_signed}, 32'b010);
    check("R10 load register", {27'd0, mem_req_reg}, 32'd11);
    check("R1 ready low while pending", {31'd0, instr_ready}, 32'd0);
    @(negedge clk);
    instr_word  = iw(8, 0, 13, 16'd5);
    repeat (2) @(posedge clk);
    #5;
    check("R11 address held", mem_req_addr, 32'd109);
    check("R11 still pending", {31'd0, mem_req_valid}, 32'd1);
    read_reg(13, "R1 held word not taken", 32'd0);
    @(negedge clk);
    mem_req_ready = 1'b1;
    @(posedge clk);
    #5;
    check("R11 request retired", {31'd0, mem_req_valid}, 32'd0);
    read_reg(13, "R1 word not taken on retire edge", 32'd0);
    @(posedge clk);
    #5;
    read_reg(13, "R1 held word taken after retire", 32'd5);
    read_reg(11, "R10 load writes no register", 32'd0);
    @(negedge clk);

    // R10 byte store with negative offset
    instr_word = iw(40, 1, 5, 16'hFFFC);
    @(posedge clk);
    #5;
    check("R10 store address", mem_req_addr, 32'd97);
    check("R10 store data", mem_req_wdata, 32'h1B234567);
    check("R10 store flags", {29'd0, mem_req_write, mem_req_word, mem_req_signed}, 32'b100);
    @(negedge clk);
    instr_word = iw(32, 0, 14, 16'd3);
    @(posedge clk);
    #5;
    check("R11 store retires", {31'd0, mem_req_valid}, 32'd0);
    @(posedge clk);
    #5;
    check("R10 signed byte load flags", {29'd0, mem_req_write, mem_req_word, mem_req_signed}, 32'b001);
    check("R10 byte load address", mem_req_addr, 32'd3);
    @(negedge clk);
    instr_valid = 1'b0;
    repeat (2) @(posedge clk);
    #5;
    read_reg(14, "R10 byte load writes no register", 32'd0);
    finish_run();
  end
endmodule